// File: doc/BRIEF.md
# Serial Character Receiver with Read Buffer

This block takes an asynchronous serial line and turns each character on it into a byte that a bus can read. A two-stage synchronizer brings in the line. A start-bit detector and a 16x oversampling bit timer then sample every bit at its centre and shift it into an internal assembly register. That register cannot be seen from outside. When a valid stop bit arrives, the assembled character is copied into an 8-bit read buffer. A one-cycle completion pulse marks each copy.

Characters are 7 or 8 data bits long and arrive least- or most-significant bit first. In 7-bit mode the character is packed against the low end of the buffer for LSB-first order and against the high end for MSB-first order. The bit left over is zero. The bus acknowledges each read with a strobe. If a new character completes before the previous one was acknowledged, the buffer keeps its old value and a sticky overrun flag is raised.

Top module: `uart_rx_buffer`

## Requirements
- R1: On reset the buffer reads 0xFF, and the completion pulse and overrun flag are 0.
- R2: A frame is one low start bit, the data bits and one high stop bit. Each bit lasts 16*DIV clock cycles and is sampled at its centre.
- R3: With `len7`=0 and `msb_first`=0, the first data bit received lands in buffer bit 0 and the eighth in bit 7.
- R4: With `len7`=0 and `msb_first`=1, the first data bit received lands in buffer bit 7 and the eighth in bit 0.
- R5: With `len7`=1 and `msb_first`=0, the seven bits fill buffer bits 0 to 6 (first bit in bit 0) and bit 7 is 0.
- R6: With `len7`=1 and `msb_first`=1, the seven bits fill buffer bits 7 down to 1 (first bit in bit 7) and bit 0 is 0.
- R7: `rx_done` is high for exactly one cycle, in the same cycle the buffer takes a new character. The buffer changes in no other cycle.
- R8: When a character completes while the previous one is still unacknowledged, `overrun` goes to 1, the buffer keeps its value and no `rx_done` is issued. The overrun flag stays at 1 until the next `rd_ack`, which clears it.
- R9: A frame whose stop bit is sampled low is discarded, and the buffer stays as it was.
- R10: A low pulse on the line that has ended by the centre of the start bit starts no frame.
- R11: Reception needs `power_en` and `rx_en` both high, and both must already have been high on the previous clock cycle. While either is low the receiver stays idle, and dropping either one part-way through a frame abandons that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_en | input | 1 | Block power/enable |
| rx_en | input | 1 | Receive enable |
| len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| msb_first | input | 1 | 1: MSB first, 0: LSB first |
| rxd | input | 1 | Serial input line, idle high |
| rd_ack | input | 1 | Buffer-read strobe from the bus |
| rx_buf | output | 8 | Receive buffer |
| rx_done | output | 1 | One-cycle pulse on each buffer update |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Some rules are checked by assertions on every cycle. These are: the buffer changes only together with a single-cycle completion pulse; no update happens in the cycle overrun rises; the overrun flag is sticky until acknowledged; the unused bit is zero in both 7-bit modes; and the receiver stays idle without the one-cycle enable history. Other behaviour can only be shown by the bench's scenarios, because it depends on sending whole serial frames. That covers the actual bit-to-position mapping in each of the four data modes, mid-bit sampling, discarding of frames with a bad stop bit, rejection of short glitches, and frames cut off by removing the enable.

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DIV = 2,
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       power_en,
  input  logic       rx_en,
  input  logic       len7,
  input  logic       msb_first,
  input  logic       rxd,
  input  logic       rd_ack,
  output logic [7:0] rx_buf,
  output logic       rx_done,
  output logic       overrun
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW = $clog2(OVS);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;

  st_t         st;
  logic [1:0]  sync;
  logic        en_q, unread;
  logic [DW-1:0] dcnt;
  logic [CW-1:0] ocnt;
  logic [2:0]  nbit;
  logic [7:0]  sh;
  logic        busy;

  wire rxs      = sync[1];
  wire act      = power_en & rx_en;
  wire tick     = (dcnt == DW'(DIV - 1));
  wire mid      = (ocnt == CW'(OVS / 2 - 1));
  wire last     = (ocnt == CW'(OVS - 1));
  wire last_bit = (nbit == (len7 ? 3'd6 : 3'd7));
  wire frame_ok = (st == STOP) && tick && last && rxs && act && en_q;
  wire [7:0] word = !len7 ? sh : (msb_first ? {sh[6:0], 1'b0} : {1'b0, sh[7:1]});

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      en_q <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      en_q <= act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      dcnt <= '0;
      ocnt <= '0;
      nbit <= '0;
      sh   <= '0;
    end else if (!(act && en_q)) begin
      st   <= IDLE;
      dcnt <= '0;
      ocnt <= '0;
      nbit <= '0;
    end else if (st == IDLE) begin
      dcnt <= '0;
      ocnt <= '0;
      nbit <= '0;
      if (!rxs) st <= START;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) begin
        ocnt <= ocnt + 1'b1;
        case (st)
          START: if (mid) begin
            ocnt <= '0;
            st   <= rxs ? IDLE : DATA;
          end
          DATA: if (last) begin
            ocnt <= '0;
            sh   <= msb_first ? {sh[6:0], rxs} : {rxs, sh[7:1]};
            nbit <= nbit + 1'b1;
            if (last_bit) st <= STOP;
          end
          STOP: if (last) st <= IDLE;
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= 8'hFF;
      rx_done <= 1'b0;
      overrun <= 1'b0;
      unread  <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (rd_ack) begin
        unread  <= 1'b0;
        overrun <= 1'b0;
      end
      if (frame_ok) begin
        if (unread && !rd_ack) overrun <= 1'b1;
        else begin
          rx_buf  <= word;
          rx_done <= 1'b1;
          unread  <= 1'b1;
        end
      end
    end
  end
endmodule

module uart_rx_buffer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       power_en,
  input logic       rx_en,
  input logic       len7,
  input logic       msb_first,
  input logic       rd_ack,
  input logic [7:0] rx_buf,
  input logic       rx_done,
  input logic       overrun,
  input logic       busy
);
  p_buf_moves_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_buf != $past(rx_buf)) |-> rx_done);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  p_no_update_on_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (!rx_done && $stable(rx_buf)));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rd_ack) |=> overrun);

  p_lsb7_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && len7 && !msb_first) |-> !rx_buf[7]);

  p_msb7_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && len7 && msb_first) |-> !rx_buf[0]);

  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(power_en && rx_en) |=> !busy);

  p_enable_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(power_en && rx_en)) |=> !busy);
endmodule

bind uart_rx_buffer uart_rx_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .power_en(power_en), .rx_en(rx_en),
  .len7(len7), .msb_first(msb_first), .rd_ack(rd_ack), .rx_buf(rx_buf),
  .rx_done(rx_done), .overrun(overrun), .busy(busy)
);

// File: tb/uart_rx_buffer_tb.sv
module uart_rx_buffer_tb;
  localparam int DIV = 2;
  localparam int OVS = 16;
  localparam int BIT = DIV * OVS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic power_en = 1'b0, rx_en = 1'b0, len7 = 1'b0, msb_first = 1'b0;
  logic rxd = 1'b1, rd_ack = 1'b0;
  logic [7:0] rx_buf;
  logic rx_done, overrun;

  int tests = 0, fails = 0;
  logic [7:0] expq[$];
  logic [7:0] exp_buf = 8'hFF;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  uart_rx_buffer #(.DIV(DIV), .OVS(OVS)) u_dut (
    .clk(clk), .rst_n(rst_n), .power_en(power_en), .rx_en(rx_en),
    .len7(len7), .msb_first(msb_first), .rxd(rxd), .rd_ack(rd_ack),
    .rx_buf(rx_buf), .rx_done(rx_done), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_done) begin
      if (expq.size() == 0) check(1'b0, "R7 unexpected rx_done", rx_buf, exp_buf);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        check(rx_buf == e, "R2-R7 received word", rx_buf, e);
      end
    end
  end

  task automatic send_frame(input logic [7:0] d, input bit l7, input bit msb,
                            input bit stop_ok, input bit expect_it);
    int n;
    n = l7 ? 7 : 8;
    @(negedge clk);
    len7 = l7;
    msb_first = msb;
    if (expect_it) begin
      exp_buf = !l7 ? d : (msb ? {d[6:0], 1'b0} : {1'b0, d[6:0]});
      expq.push_back(exp_buf);
    end
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = msb ? d[n-1-i] : d[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (stop_ok ? BIT : BIT / 2 + 4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rx_buf == 8'hFF, "R1 reset buffer", rx_buf, 8'hFF);
    check(rx_done == 1'b0, "R1 reset done", {7'd0, rx_done}, 8'h00);
    check(overrun == 1'b0, "R1 reset overrun", {7'd0, overrun}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: disabled receiver ignores a frame
    send_frame(8'h12, 1'b0, 1'b0, 1'b1, 1'b0);
    check(rx_buf == 8'hFF, "R11 disabled frame ignored", rx_buf, 8'hFF);

    power_en = 1'b1;
    rx_en = 1'b1;
    repeat (2) @(negedge clk);

    send_frame(8'hA5, 1'b0, 1'b0, 1'b1, 1'b1);   // R3
    ack();
    send_frame(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1);   // R4
    ack();
    send_frame(8'h4B, 1'b0, 1'b1, 1'b1, 1'b1);   // R4 asymmetric
    ack();
    send_frame(8'h55, 1'b1, 1'b0, 1'b1, 1'b1);   // R5
    check(rx_buf == 8'h55, "R5 7-bit LSB placement", rx_buf, 8'h55);
    ack();
    send_frame(8'h2B, 1'b1, 1'b1, 1'b1, 1'b1);   // R6
    check(rx_buf == 8'h56, "R6 7-bit MSB placement", rx_buf, 8'h56);
    ack();
    send_frame(8'h7F, 1'b1, 1'b0, 1'b1, 1'b1);   // R5 top bit zero
    check(rx_buf == 8'h7F, "R5 bit7 zero", rx_buf, 8'h7F);
    ack();
    send_frame(8'h7F, 1'b1, 1'b1, 1'b1, 1'b1);   // R6 low bit zero
    check(rx_buf == 8'hFE, "R6 bit0 zero", rx_buf, 8'hFE);
    ack();

    // R8: overrun
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1, 1'b1);
    send_frame(8'h18, 1'b0, 1'b0, 1'b1, 1'b0);
    check(overrun == 1'b1, "R8 overrun set", {7'd0, overrun}, 8'h01);
    check(rx_buf == 8'hC3, "R8 buffer kept", rx_buf, 8'hC3);
    repeat (5) @(negedge clk);
    check(overrun == 1'b1, "R8 overrun sticky", {7'd0, overrun}, 8'h01);
    ack();
    check(overrun == 1'b0, "R8 overrun cleared by read", {7'd0, overrun}, 8'h00);
    send_frame(8'h81, 1'b0, 1'b0, 1'b1, 1'b1);
    check(rx_buf == 8'h81, "R8 receive after clear", rx_buf, 8'h81);
    ack();

    // R9: bad stop bit
    send_frame(8'h66, 1'b0, 1'b0, 1'b0, 1'b0);
    check(rx_buf == 8'h81, "R9 framing error discards", rx_buf, 8'h81);

    // R10: short glitch
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    check(rx_buf == 8'h81, "R10 glitch ignored", rx_buf, 8'h81);

    // R11: enable dropped mid-frame
    fork
      send_frame(8'h99, 1'b0, 1'b0, 1'b1, 1'b0);
      begin
        repeat (4 * BIT) @(negedge clk);
        rx_en = 1'b0;
      end
    join
    repeat (2 * BIT) @(negedge clk);
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
    check(rx_buf == 8'h81, "R11 abandoned frame", rx_buf, 8'h81);
    send_frame(8'h0F, 1'b0, 1'b0, 1'b1, 1'b1);
    check(rx_buf == 8'h0F, "R11 resumes after re-enable", rx_buf, 8'h0F);

    check(expq.size() == 0, "R7 all expected words seen", 8'(expq.size()), 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule